// File: doc/BRIEF.md
# Hysteresis Interrupt Status Controller

This block gathers interrupt causes from a network interface's receive and transmit machinery into a latched status word. It qualifies that word with a mask and turns the result into one interrupt request line towards the processor. Event pulses are OR-ed into status. Software reads status, which clears it, or clears chosen bits by writing ones. It also programs the mask and issues commands that raise a software interrupt or reset the block.

Two causes are watermark causes: the receive queue climbing above its high mark, and the transmit queue falling below its low mark. Each one is forwarded only after its queue has first been through its extreme, empty for receive and full for transmit. This stops the request from chattering while a queue hovers around its mark. Forwarded causes in a no-delay class raise the request at once. Any other forwarded cause starts a programmable moderation delay. The request is gated by a configuration enable and drops as soon as status becomes zero.

Top module: `irq_hyst_ctrl`

## Requirements
- R1: Each `evt_i` bit set in a cycle is OR-ed into status at that clock edge. It is kept even if a status read or clear happens in the same cycle. Bit positions: 0 soft, 1 rx packet, 2 rx high, 3 rx empty, 4 rx DMA, 5 tx packet, 6 tx low, 7 tx full, 8 tx DMA; higher bits are generic causes.
- R2: A read with `reg_sel_i`=0 returns the status held before that edge on `reg_rdata_o` after the edge, and clears status.
- R3: A write with `reg_sel_i`=0 clears exactly the status bits written as 1. All other bits are kept.
- R4: `reg_sel_i`=1 reads and writes the mask. After reset the mask is 0x047 (soft, rx packet, rx high, tx low).
- R5: The rx-high cause (bit 2) is forwarded only while an rx-empty flag is set. A post of bit 3 sets that flag. Forwarding bit 2 clears it. While the flag is clear, bit 2 stays latched in status but raises nothing.
- R6: The tx-low cause (bit 6) is forwarded in the same way, under a tx-full flag that a post of bit 7 sets.
- R7: Forwarding is evaluated only in cycles where some cause is posted. If any forwarded cause is in the no-delay class (default bits 0, 3, 7), `irq_o` rises at the same edge that latches the cause.
- R8: Otherwise `irq_o` rises at the (D+1)-th edge after the latching edge, with D = `dly_cycles_i`. Further delayed causes during the wait do not restart it.
- R9: When status becomes zero, the request and any pending delay are dropped, and `irq_o` falls at that edge.
- R10: `irq_o` is low whenever `cfg_int_en_i` was low before the edge. A request held while disabled appears at the first edge after enabling.
- R11: A write with `reg_sel_i`=2 and bit 0 set posts the soft cause. With bit 1 set it resets status to 0, the mask to 0x047 and both flags, and pulses `soft_reset_o` for one cycle. Reset wins over soft in the same write.
- R12: `reg_rdata_o` is registered. Reads with `reg_sel_i`=2 or 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | ST_W | Cause pulses, one bit per cause |
| cfg_int_en_i | input | 1 | Interrupt output enable from configuration |
| dly_cycles_i | input | DLY_W | Moderation delay in cycles |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 command, 3 reserved |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | ST_W | Write data |
| reg_rdata_o | output | ST_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| soft_reset_o | output | 1 | One-cycle pulse on a reset command |

## Verification
The bench targets the hysteresis flags: a watermark cause posted before its extreme, the same cause after the extreme, and a repeat after the flag was used. A design without the flags interrupts too often; one that never clears them fires on every repeat. It times the request exactly for both classes and for two delay values, where an off-by-one counter shows up as an early or late edge. It also covers a post that coincides with a clear-on-read, which a wrong priority would lose. Finally it checks that a reset command clears the flags and beats a soft interrupt written alongside it.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  // cause bit positions
  localparam int C_SOFT    = 0;
  localparam int C_RXPKT   = 1;
  localparam int C_RXHIGH  = 2;
  localparam int C_RXEMPTY = 3;
  localparam int C_RXDMA   = 4;
  localparam int C_TXPKT   = 5;
  localparam int C_TXLOW   = 6;
  localparam int C_TXFULL  = 7;
  localparam int C_TXDMA   = 8;
  localparam int NUM_FIXED = 9;

  // number of watermark channels with hysteresis
  localparam int NWM = 2;

  // command register bits
  localparam int CMD_SOFT_BIT  = 0;
  localparam int CMD_RESET_BIT = 1;

  localparam logic [NUM_FIXED-1:0] MASK_DEF9 =
    NUM_FIXED'((1 << C_SOFT) | (1 << C_RXPKT) | (1 << C_RXHIGH) | (1 << C_TXLOW));

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CMD    = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  // watermark cause guarded by channel g
  function automatic int wm_level(input int g);
    return (g == 0) ? C_RXHIGH : C_TXLOW;
  endfunction

  // extreme cause that arms channel g
  function automatic int wm_arm(input int g);
    return (g == 0) ? C_RXEMPTY : C_TXFULL;
  endfunction
endpackage

// File: rtl/ihc_regfile.sv
module ihc_regfile
  import ihc_pkg::*;
#(
  parameter int ST_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] evt_i,
  input  logic [1:0]      reg_sel_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [ST_W-1:0] reg_wdata_i,
  output logic [ST_W-1:0] status_q,
  output logic [ST_W-1:0] status_nx,
  output logic [ST_W-1:0] mask_q,
  output logic [ST_W-1:0] post_vec,
  output logic            cmd_reset,
  output logic [ST_W-1:0] reg_rdata_o,
  output logic            soft_reset_o
);
  localparam logic [ST_W-1:0] MASK_DEF = ST_W'(MASK_DEF9);

  logic            wr_status, wr_mask, wr_cmd, rd_status, cmd_soft;
  logic [ST_W-1:0] clr_vec, mask_nx, soft_vec;

  always_comb begin
    wr_status = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
    wr_mask   = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);
    wr_cmd    = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CMD);
    rd_status = reg_rd_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
    cmd_reset = wr_cmd && reg_wdata_i[CMD_RESET_BIT];
    cmd_soft  = wr_cmd && reg_wdata_i[CMD_SOFT_BIT];
    soft_vec  = '0;
    soft_vec[C_SOFT] = cmd_soft;
    post_vec  = cmd_reset ? '0 : (evt_i | soft_vec);
    if (rd_status)      clr_vec = '1;
    else if (wr_status) clr_vec = reg_wdata_i;
    else                clr_vec = '0;
    status_nx = cmd_reset ? '0 : ((status_q & ~clr_vec) | post_vec);
    if (cmd_reset)    mask_nx = MASK_DEF;
    else if (wr_mask) mask_nx = reg_wdata_i;
    else              mask_nx = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= '0;
      mask_q       <= MASK_DEF;
      reg_rdata_o  <= '0;
      soft_reset_o <= 1'b0;
    end else begin
      status_q     <= status_nx;
      mask_q       <= mask_nx;
      soft_reset_o <= cmd_reset;
      if (reg_rd_i) begin
        case (reg_sel_e'(reg_sel_i))
          SEL_STATUS: reg_rdata_o <= status_q;
          SEL_MASK:   reg_rdata_o <= mask_q;
          default:    reg_rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ihc_qualifier.sv
module ihc_qualifier
  import ihc_pkg::*;
#(
  parameter int              ST_W         = 12,
  parameter logic [ST_W-1:0] NODELAY_MASK = ST_W'(9'h089)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] status_nx,
  input  logic [ST_W-1:0] mask_q,
  input  logic [ST_W-1:0] post_vec,
  input  logic            cmd_reset,
  output logic [NWM-1:0]  arm_q,
  output logic [ST_W-1:0] fwd,
  output logic            fire_now,
  output logic            fire_late
);
  logic [ST_W-1:0] cand;
  logic [ST_W-1:0] strip_oh [NWM];
  logic [ST_W-1:0] strip;
  logic            post_any;

  assign cand     = status_nx & mask_q;
  assign post_any = |post_vec;

  for (genvar g = 0; g < NWM; g++) begin : g_wm
    localparam int LV = wm_level(g);
    localparam int AR = wm_arm(g);
    logic consume;

    assign strip_oh[g] = arm_q[g] ? '0 : (ST_W'(1) << LV);
    assign consume     = arm_q[g] && cand[LV] && post_any;

    always_ff @(posedge clk) begin
      if (rst || cmd_reset) arm_q[g] <= 1'b0;
      else                  arm_q[g] <= (arm_q[g] && !consume) || post_vec[AR];
    end
  end

  always_comb begin
    strip = '0;
    for (int i = 0; i < NWM; i++) strip = strip | strip_oh[i];
    fwd       = cand & ~strip;
    fire_now  = post_any && |(fwd & NODELAY_MASK);
    fire_late = post_any && |fwd && !fire_now;
  end
endmodule

// File: rtl/ihc_moderator.sv
module ihc_moderator #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             status_zero,
  input  logic             fire_now,
  input  logic             fire_late,
  input  logic             cfg_int_en_i,
  input  logic [DLY_W-1:0] dly_cycles_i,
  output logic             req_q,
  output logic             irq_o
);
  logic             run_q, run_n, req_n;
  logic [DLY_W-1:0] cnt_q, cnt_n;

  always_comb begin
    req_n = req_q;
    run_n = run_q;
    cnt_n = cnt_q;
    if (status_zero) begin
      req_n = 1'b0;
      run_n = 1'b0;
      cnt_n = '0;
    end else begin
      if (run_q) begin
        if (cnt_q == '0) begin
          req_n = 1'b1;
          run_n = 1'b0;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      if (fire_now) begin
        req_n = 1'b1;
        run_n = 1'b0;
      end else if (fire_late && !run_q && !req_q) begin
        run_n = 1'b1;
        cnt_n = dly_cycles_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      req_q <= req_n;
      run_q <= run_n;
      cnt_q <= cnt_n;
      irq_o <= req_n && cfg_int_en_i;
    end
  end
endmodule

// File: rtl/irq_hyst_ctrl.sv
module irq_hyst_ctrl
  import ihc_pkg::*;
#(
  parameter int              ST_W         = 12,
  parameter int              DLY_W        = 8,
  parameter logic [ST_W-1:0] NODELAY_MASK = ST_W'(9'h089)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ST_W-1:0]  evt_i,
  input  logic             cfg_int_en_i,
  input  logic [DLY_W-1:0] dly_cycles_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [ST_W-1:0]  reg_wdata_i,
  output logic [ST_W-1:0]  reg_rdata_o,
  output logic             irq_o,
  output logic             soft_reset_o
);
  logic [ST_W-1:0] status_q, status_nx, mask_q, post_vec, fwd;
  logic [NWM-1:0]  arm_q;
  logic            cmd_reset, fire_now, fire_late, req_q;

  ihc_regfile #(.ST_W(ST_W)) u_regs (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i),
    .status_q(status_q), .status_nx(status_nx), .mask_q(mask_q),
    .post_vec(post_vec), .cmd_reset(cmd_reset),
    .reg_rdata_o(reg_rdata_o), .soft_reset_o(soft_reset_o)
  );

  ihc_qualifier #(.ST_W(ST_W), .NODELAY_MASK(NODELAY_MASK)) u_qual (
    .clk(clk), .rst(rst), .status_nx(status_nx), .mask_q(mask_q),
    .post_vec(post_vec), .cmd_reset(cmd_reset), .arm_q(arm_q),
    .fwd(fwd), .fire_now(fire_now), .fire_late(fire_late)
  );

  ihc_moderator #(.DLY_W(DLY_W)) u_mod (
    .clk(clk), .rst(rst), .status_zero(status_nx == '0),
    .fire_now(fire_now), .fire_late(fire_late),
    .cfg_int_en_i(cfg_int_en_i), .dly_cycles_i(dly_cycles_i),
    .req_q(req_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/ihc_checker.sv
module ihc_checker
  import ihc_pkg::*;
#(
  parameter int ST_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [ST_W-1:0] evt_i,
  input logic            cfg_int_en_i,
  input logic [1:0]      reg_sel_i,
  input logic            reg_wr_i,
  input logic            reg_rd_i,
  input logic [ST_W-1:0] reg_wdata_i,
  input logic            irq_o,
  input logic            soft_reset_o,
  input logic [ST_W-1:0] status_q,
  input logic [ST_W-1:0] mask_q,
  input logic [ST_W-1:0] fwd,
  input logic [NWM-1:0]  arm_q,
  input logic            fire_now,
  input logic            req_q
);
  logic rst_cmd;
  assign rst_cmd = reg_wr_i && (reg_sel_i == 2'd2) && reg_wdata_i[CMD_RESET_BIT];

  // R1
  post_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0 && !rst_cmd) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_sel_i == 2'd0 && evt_i == '0 && !reg_wr_i) |=> (status_q == '0));

  // R5
  rx_hyst_chk: assert property (@(posedge clk) disable iff (rst)
    fwd[C_RXHIGH] |-> arm_q[0]);

  // R6
  tx_hyst_chk: assert property (@(posedge clk) disable iff (rst)
    fwd[C_TXLOW] |-> arm_q[1]);

  // R7
  no_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_now && cfg_int_en_i) |=> irq_o);

  // R9
  req_status_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (status_q != '0));

  // R10
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_int_en_i |=> !irq_o);

  // R11
  cmd_reset_chk: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |-> (status_q == '0 && mask_q == ST_W'(MASK_DEF9)));
endmodule

bind irq_hyst_ctrl ihc_checker #(.ST_W(ST_W)) u_ihc_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .cfg_int_en_i(cfg_int_en_i),
  .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .soft_reset_o(soft_reset_o),
  .status_q(status_q), .mask_q(mask_q), .fwd(fwd), .arm_q(arm_q),
  .fire_now(fire_now), .req_q(req_q)
);

// File: tb/test_irq_hyst_ctrl.sv
module test_irq_hyst_ctrl;
  localparam int W = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  evt = '0;
  logic          en = 1'b1;
  logic [DW-1:0] dly = 8'd2;
  logic [1:0]    sel = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          irq, srst;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_hyst_ctrl #(.ST_W(W), .DLY_W(DW)) i_irq_hyst_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .cfg_int_en_i(en), .dly_cycles_i(dly),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .soft_reset_o(srst)
  );

  // op: 0 idle, 1 read, 2 write
  typedef struct packed {
    logic [W-1:0] evt;
    logic [1:0]   op;
    logic [1:0]   sel;
    logic [W-1:0] wd;
    logic [W-1:0] exp_rd;
    logic         exp_irq;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{12'h002, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd8},  // R8 delayed post
    '{12'h000, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd8},
    '{12'h000, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd8},
    '{12'h000, 2'd0, 2'd0, 12'h000, 12'h000, 1'b1, 4'd8},  // D+1 edges
    '{12'h000, 2'd1, 2'd0, 12'h000, 12'h002, 1'b0, 4'd2},  // R2 R9
    '{12'h004, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd5},  // R5 not armed
    '{12'h008, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd5},  // arm
    '{12'h004, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd5},  // forwarded, delayed
    '{12'h000, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd5},
    '{12'h000, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd5},
    '{12'h000, 2'd0, 2'd0, 12'h000, 12'h000, 1'b1, 4'd5},
    '{12'h000, 2'd2, 2'd0, 12'h004, 12'h000, 1'b1, 4'd3},  // R3 W1C keeps 0x008
    '{12'h000, 2'd1, 2'd0, 12'h000, 12'h008, 1'b0, 4'd3},
    '{12'h004, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd5},  // flag used up
    '{12'h000, 2'd2, 2'd2, 12'h001, 12'h000, 1'b1, 4'd7},  // R7 R11 soft, immediate
    '{12'h000, 2'd1, 2'd0, 12'h000, 12'h005, 1'b0, 4'd2},
    '{12'h000, 2'd2, 2'd1, 12'h000, 12'h000, 1'b0, 4'd4},  // R4 mask write
    '{12'h001, 2'd0, 2'd0, 12'h000, 12'h000, 1'b0, 4'd4},  // masked
    '{12'h000, 2'd1, 2'd1, 12'h000, 12'h000, 1'b0, 4'd4},
    '{12'h000, 2'd1, 2'd0, 12'h000, 12'h001, 1'b0, 4'd1}   // R1 latched though masked
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at the following negedge
  task automatic step(input logic [W-1:0] e, input logic [1:0] op,
                      input logic [1:0] s, input logic [W-1:0] d);
    evt = e; rd = (op == 2'd1); wr = (op == 2'd2); sel = s; wdata = d;
    @(negedge clk);
    evt = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic idle_chk(input int n, input logic exp_irq, input string tag);
    for (int k = 0; k < n; k++) begin
      step('0, 2'd0, 2'd0, '0);
      check(tag, "irq idle", int'(irq), int'(exp_irq));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state: R4 mask default, status empty
    check("R4", "irq after reset", int'(irq), 0);
    step('0, 2'd1, 2'd1, '0);
    check("R4", "mask reset", int'(rdata), 'h047);
    step('0, 2'd1, 2'd0, '0);
    check("R2", "status reset", int'(rdata), 0);

    for (int v = 0; v < NV; v++) begin
      step(TBL[v].evt, TBL[v].op, TBL[v].sel, TBL[v].wd);
      check($sformatf("R%0d", TBL[v].req), $sformatf("vec %0d irq", v),
            int'(irq), int'(TBL[v].exp_irq));
      if (TBL[v].op == 2'd1)
        check($sformatf("R%0d", TBL[v].req), $sformatf("vec %0d rdata", v),
              int'(rdata), int'(TBL[v].exp_rd));
    end

    // R11 reset command
    step('0, 2'd2, 2'd2, 12'h002);
    check("R11", "soft_reset pulse", int'(srst), 1);
    step('0, 2'd1, 2'd1, '0);
    check("R11", "pulse one cycle", int'(srst), 0);
    check("R11", "mask restored", int'(rdata), 'h047);
    step('0, 2'd2, 2'd2, 12'h003);
    check("R11", "reset beats soft irq", int'(irq), 0);
    step('0, 2'd1, 2'd0, '0);
    check("R11", "reset beats soft status", int'(rdata), 0);

    // R6 tx-low hysteresis
    step(12'h040, 2'd0, 2'd0, '0);
    check("R6", "tx low unarmed", int'(irq), 0);
    idle_chk(4, 1'b0, "R6");
    step('0, 2'd1, 2'd0, '0);
    check("R6", "tx low latched", int'(rdata), 'h040);
    step(12'h080, 2'd0, 2'd0, '0);
    check("R6", "tx full masked", int'(irq), 0);
    step(12'h040, 2'd0, 2'd0, '0);
    check("R6", "tx low armed start", int'(irq), 0);
    idle_chk(2, 1'b0, "R6");
    idle_chk(1, 1'b1, "R6");
    step('0, 2'd1, 2'd0, '0);
    check("R6", "status tx", int'(rdata), 'h0C0);
    check("R9", "drop on clear", int'(irq), 0);

    // R8 programmable delay 5
    dly = 8'd5;
    step(12'h002, 2'd0, 2'd0, '0);
    check("R8", "delay5 post", int'(irq), 0);
    idle_chk(5, 1'b0, "R8");
    idle_chk(1, 1'b1, "R8");
    step('0, 2'd1, 2'd0, '0);
    check("R8", "delay5 clear", int'(irq), 0);

    // R10 enable gating
    dly = 8'd2;
    en = 1'b0;
    step('0, 2'd2, 2'd2, 12'h001);
    check("R10", "disabled soft", int'(irq), 0);
    idle_chk(3, 1'b0, "R10");
    en = 1'b1;
    idle_chk(1, 1'b1, "R10");
    step('0, 2'd1, 2'd0, '0);
    check("R10", "status soft", int'(rdata), 'h001);

    // R9 cancel pending delay
    step(12'h002, 2'd0, 2'd0, '0);
    step('0, 2'd1, 2'd0, '0);
    check("R9", "cancel read", int'(rdata), 'h002);
    idle_chk(4, 1'b0, "R9");

    // R1 post during clear-on-read
    step(12'h100, 2'd0, 2'd0, '0);
    step(12'h020, 2'd1, 2'd0, '0);
    check("R1", "read before race", int'(rdata), 'h100);
    step('0, 2'd1, 2'd0, '0);
    check("R1", "post kept in race", int'(rdata), 'h020);

    // R5 flag cleared by reset command
    step(12'h008, 2'd0, 2'd0, '0);
    step('0, 2'd2, 2'd2, 12'h002);
    step(12'h004, 2'd0, 2'd0, '0);
    idle_chk(4, 1'b0, "R5");
    step('0, 2'd1, 2'd0, '0);
    check("R5", "rx high latched", int'(rdata), 'h004);

    // R12 command and reserved reads
    step('0, 2'd1, 2'd2, '0);
    check("R12", "cmd read", int'(rdata), 0);
    step('0, 2'd1, 2'd3, '0);
    check("R12", "rsvd read", int'(rdata), 0);

    finish_run();
  end
endmodule